// File: doc/BRIEF.md
# Clock Controller Register Bank

This block is the software-visible register bank of a clock-control peripheral. It holds 26 words of 32 bits. A simple synchronous bus port reaches them. A request carries a 12-bit byte address, and bits [11:2] of that address select the word. Every word has its own reset value. Eight words accept software writes, and each of those has its own write mask. The remaining in-range words are read-only and always hold their reset contents.

The main control word, the first divider word and the three gating words also drive output ports. Downstream clock logic uses them directly. Reads, writes to read-only words and accesses beyond the last word all get a registered response one cycle after the request. A failed access raises a one-cycle error pulse in that response.

Top module: `clkctl_regfile`

## Requirements
- R1: On a rising edge with rst_n low, every word loads its reset value, and rdata and err go to zero. The non-zero reset values are: index 0 = 0x074b0b7d, 1 = 0xff870b48, 2 = 0x49fcfe7f, 3 = 0x007f0000, 4 = 0x04001800, 5 = 0x04051c03, 6 = 0x04043001, 7 = 0x00000280, 8 to 11 = 0xffffffff, 18 = 0x00004040, 23 = 0x80209828, 24 = 0x00aa0000 and 25 = 0x00000285. Every other index resets to zero.
- R2: The word index is addr[11:2]. Address bits [1:0] have no effect on reads or writes.
- R3: A read (req=1, we=0) with index 0 to 25 returns the stored word on rdata one cycle later, with err=0.
- R4: A read with index 26 or above returns rdata=0 with err=1 one cycle later.
- R5: A write to index 0 stores (wdata AND 0x3b6fdfff) OR 0x04000000. Bit 26 is therefore 1 after every such write.
- R6: A write to index 1 stores wdata AND 0xff9f3fff. A write to index 4 or to index 6 stores wdata AND 0xbfff3fff.
- R7: A write to index 2, 8, 9 or 10 stores all 32 bits of wdata.
- R8: A write to any other index, in range or not, changes no word. Its response has err=1. Every write response has rdata=0, and a successful write has err=0.
- R9: err is high only in the cycle right after a request, so each failed request gives a pulse one cycle wide.
- R10: ctrl_q always equals word 0, div_q equals word 1, and gate_q holds word 8 in bits [31:0], word 9 in bits [63:32] and word 10 in bits [95:64]. These outputs change only after a write.
- R11: A write presented while rst_n is low is ignored. The word holds its reset value afterwards.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| req | input | 1 | Access request, one transfer per cycle |
| we | input | 1 | 1 = write, 0 = read |
| addr | input | 12 | Byte address; bits [11:2] select the word |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Registered read data, zero unless a good read |
| err | output | 1 | Error pulse aligned with the response |
| ctrl_q | output | 32 | Live copy of word 0 |
| div_q | output | 32 | Live copy of word 1 |
| gate_q | output | 96 | Live copies of words 10, 9, 8 (high to low) |

## Verification
The embedded properties assume two things about the inputs: they are known (not X) whenever rst_n is high, and they change only away from the rising clock edge. The properties also look one cycle back, so they weigh that cycle only when rst_n was high in it. For that reason a write held during reset cannot trip them. The bench drives every input on the falling edge and holds reset for several cycles. It sweeps every index up to 29, plus a few distant out-of-range indices, under several data patterns. It rotates the low address bits so that unaligned offsets reach every index.

// File: rtl/clkctl_regs_pkg.sv
// Package: per-word reset values, write masks and forced bits of the clock
// controller register bank. Assumes 32-bit words; indices not listed reset
// to zero and are read-only.
package clkctl_regs_pkg;

    localparam int unsigned NUM_REGS  = 26;
    localparam int unsigned DATA_W    = 32;
    localparam int unsigned ADDR_W    = 12;
    localparam int unsigned CTRL_IDX  = 0;
    localparam int unsigned DIV_IDX   = 1;
    localparam int unsigned GATE_IDX  = 8;
    localparam int unsigned GATE_NUM  = 3;

    // Reset contents of each word.
    function automatic logic [31:0] reset_val(input int unsigned idx);
        case (idx)
            0:             return 32'h074b0b7d;
            1:             return 32'hff870b48;
            2:             return 32'h49fcfe7f;
            3:             return 32'h007f0000;
            4:             return 32'h04001800;
            5:             return 32'h04051c03;
            6:             return 32'h04043001;
            7:             return 32'h00000280;
            8, 9, 10, 11:  return 32'hffffffff;
            18:            return 32'h00004040;
            23:            return 32'h80209828;
            24:            return 32'h00aa0000;
            25:            return 32'h00000285;
            default:       return 32'h0;
        endcase
    endfunction

    // Bits a write may change; zero for read-only words.
    function automatic logic [31:0] write_mask(input int unsigned idx);
        case (idx)
            0:             return 32'h3b6fdfff;
            1:             return 32'hff9f3fff;
            4, 6:          return 32'hbfff3fff;
            2, 8, 9, 10:   return 32'hffffffff;
            default:       return 32'h0;
        endcase
    endfunction

    // Bits set to one on every write to the word.
    function automatic logic [31:0] force_bits(input int unsigned idx);
        return (idx == 0) ? 32'h04000000 : 32'h0;
    endfunction

    // Whether software may write the word.
    function automatic logic is_writable(input int unsigned idx);
        case (idx)
            0, 1, 2, 4, 6, 8, 9, 10: return 1'b1;
            default:                 return 1'b0;
        endcase
    endfunction

endpackage

// File: rtl/clkctl_addr_dec.sv
// Address decoder: turns a byte address into a word index and classifies it.
// Assumes word-aligned registers; the two low address bits are discarded.
module clkctl_addr_dec #(
    parameter int unsigned ADDR_W   = 12,
    parameter int unsigned NUM_REGS = 26,
    localparam int unsigned IDX_W   = ADDR_W - 2
) (
    input  logic [ADDR_W-1:0] addr,
    output logic [IDX_W-1:0]  idx,
    output logic              in_range,
    output logic              wr_ok
);
    logic [1:0] unused_lo;

    assign unused_lo = addr[1:0];
    assign idx       = addr[ADDR_W-1:2];

    // Classify the index: present, and writable by software.
    always_comb begin
        in_range = (idx < IDX_W'(NUM_REGS));
        wr_ok    = in_range && clkctl_regs_pkg::is_writable(int'(idx));
    end
endmodule

// File: rtl/clkctl_reg_slot.sv
// One register word: loads RST_VAL on reset, takes masked data plus forced
// bits on a write strobe. Assumes wr_en is only raised for writable words.
module clkctl_reg_slot #(
    parameter int unsigned        DATA_W  = 32,
    parameter logic [DATA_W-1:0]  RST_VAL = '0,
    parameter logic [DATA_W-1:0]  MASK    = '0,
    parameter logic [DATA_W-1:0]  FORCE   = '0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] q
);
    // Hold the word; reset wins over any write.
    always_ff @(posedge clk) begin
        if (!rst_n)     q <= RST_VAL;
        else if (wr_en) q <= (wdata & MASK) | FORCE;
    end
endmodule

// File: rtl/clkctl_rd_mux.sv
// Read multiplexer: selects one stored word by index. Assumes the caller
// qualifies the result with an in-range flag; out-of-range gives zero.
module clkctl_rd_mux #(
    parameter int unsigned DATA_W   = 32,
    parameter int unsigned NUM_REGS = 26,
    parameter int unsigned IDX_W    = 10
) (
    input  logic [DATA_W-1:0] words [NUM_REGS],
    input  logic [IDX_W-1:0]  idx,
    output logic [DATA_W-1:0] word
);
    // Pick the addressed word.
    always_comb begin
        word = '0;
        for (int i = 0; i < NUM_REGS; i++) begin
            if (idx == IDX_W'(i)) word = words[i];
        end
    end
endmodule

// File: rtl/clkctl_regfile.sv
// Clock controller register bank top. Single-cycle requests, response one
// cycle later; synchronous active-low reset. Assumes inputs are known while
// rst_n is high.
module clkctl_regfile #(
    parameter int unsigned NUM_REGS = clkctl_regs_pkg::NUM_REGS,
    parameter int unsigned DATA_W   = clkctl_regs_pkg::DATA_W,
    parameter int unsigned ADDR_W   = clkctl_regs_pkg::ADDR_W,
    parameter int unsigned GATE_NUM = clkctl_regs_pkg::GATE_NUM,
    localparam int unsigned IDX_W   = ADDR_W - 2
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         req,
    input  logic                         we,
    input  logic [ADDR_W-1:0]            addr,
    input  logic [DATA_W-1:0]            wdata,
    output logic [DATA_W-1:0]            rdata,
    output logic                         err,
    output logic [DATA_W-1:0]            ctrl_q,
    output logic [DATA_W-1:0]            div_q,
    output logic [GATE_NUM*DATA_W-1:0]   gate_q
);
    logic [IDX_W-1:0]  idx;
    logic              in_range;
    logic              wr_ok;
    logic [DATA_W-1:0] words [NUM_REGS];
    logic [DATA_W-1:0] rd_word;
    logic              wr_go;

    clkctl_addr_dec #(.ADDR_W(ADDR_W), .NUM_REGS(NUM_REGS)) u_dec (
        .addr(addr), .idx(idx), .in_range(in_range), .wr_ok(wr_ok)
    );

    assign wr_go = rst_n && req && we && wr_ok;

    for (genvar i = 0; i < NUM_REGS; i++) begin : g_slot
        clkctl_reg_slot #(
            .DATA_W (DATA_W),
            .RST_VAL(DATA_W'(clkctl_regs_pkg::reset_val(i))),
            .MASK   (DATA_W'(clkctl_regs_pkg::write_mask(i))),
            .FORCE  (DATA_W'(clkctl_regs_pkg::force_bits(i)))
        ) u_slot (
            .clk(clk), .rst_n(rst_n),
            .wr_en(wr_go && (idx == IDX_W'(i))),
            .wdata(wdata), .q(words[i])
        );
    end

    clkctl_rd_mux #(.DATA_W(DATA_W), .NUM_REGS(NUM_REGS), .IDX_W(IDX_W)) u_mux (
        .words(words), .idx(idx), .word(rd_word)
    );

    assign ctrl_q = words[clkctl_regs_pkg::CTRL_IDX];
    assign div_q  = words[clkctl_regs_pkg::DIV_IDX];
    for (genvar g = 0; g < GATE_NUM; g++) begin : g_gate
        assign gate_q[g*DATA_W +: DATA_W] = words[clkctl_regs_pkg::GATE_IDX + g];
    end

    // Register the bus response: data on good reads, error on bad accesses.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rdata <= '0;
            err   <= 1'b0;
        end else begin
            rdata <= (req && !we && in_range) ? rd_word : '0;
            err   <= req && (we ? !wr_ok : !in_range);
        end
    end

    // R3
    good_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(req && !we && in_range)) |-> !err);

    // R4
    oor_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(req && !we && !in_range)) |-> (err && rdata == '0));

    // R5
    ctrl_force_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(req && we && idx == '0)) |-> ctrl_q[26]);

    // R8
    ro_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(req && we && !wr_ok))
        |-> (err && $stable(ctrl_q) && $stable(div_q) && $stable(gate_q)));

    // R9
    err_needs_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && err) |-> $past(req));

    // R10
    gate_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && !$past(req && we))
        |-> ($stable(gate_q) && $stable(ctrl_q) && $stable(div_q)));
endmodule

// File: tb/clkctl_regfile_bench.sv
module clkctl_regfile_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req = 1'b0;
    logic        we = 1'b0;
    logic [11:0] addr = '0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata;
    logic        err;
    logic [31:0] ctrl_q, div_q;
    logic [95:0] gate_q;

    int checks = 0;
    int errors = 0;
    logic [31:0] model [26];

    always #2 clk = ~clk;

    clkctl_regfile u_clkctl_regfile (
        .clk(clk), .rst_n(rst_n), .req(req), .we(we), .addr(addr),
        .wdata(wdata), .rdata(rdata), .err(err),
        .ctrl_q(ctrl_q), .div_q(div_q), .gate_q(gate_q)
    );

    function automatic logic [31:0] exp_rst(int i);
        case (i)
            0: return 32'h074b0b7d;  1: return 32'hff870b48;
            2: return 32'h49fcfe7f;  3: return 32'h007f0000;
            4: return 32'h04001800;  5: return 32'h04051c03;
            6: return 32'h04043001;  7: return 32'h00000280;
            8, 9, 10, 11: return 32'hffffffff;
            18: return 32'h00004040; 23: return 32'h80209828;
            24: return 32'h00aa0000; 25: return 32'h00000285;
            default: return 32'h0;
        endcase
    endfunction

    function automatic logic exp_wr(int i);
        return (i == 0 || i == 1 || i == 2 || i == 4 || i == 6 || i == 8 || i == 9 || i == 10);
    endfunction

    function automatic logic [31:0] exp_store(int i, logic [31:0] d);
        case (i)
            0: return (d & 32'h3b6fdfff) | 32'h04000000;
            1: return d & 32'hff9f3fff;
            4, 6: return d & 32'hbfff3fff;
            default: return d;
        endcase
    endfunction

    task automatic check(string tag, logic [95:0] act, logic [95:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic model_reset();
        for (int i = 0; i < 26; i++) model[i] = exp_rst(i);
    endtask

    // One request; returns after the response is visible (falling edge).
    task automatic access(logic w, logic [11:0] a, logic [31:0] d);
        @(negedge clk);
        req = 1'b1; we = w; addr = a; wdata = d;
        @(negedge clk);
        req = 1'b0; we = 1'b0;
    endtask

    task automatic check_ports(string tag);
        check({tag, " ctrl_q"}, ctrl_q, model[0]);
        check({tag, " div_q"}, div_q, model[1]);
        check({tag, " gate_q"}, gate_q, {model[10], model[9], model[8]});
    endtask

    task automatic read_all(string tag, int lo);
        for (int i = 0; i < 26; i++) begin
            access(1'b0, 12'(i * 4 + ((i + lo) % 4)), 32'h0);
            check({tag, " rdata"}, rdata, model[i]);
            check({tag, " err"}, err, 1'b0);
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        logic [31:0] pats [5] = '{32'hffffffff, 32'h0, 32'ha5a5a5a5, 32'h5a5a5a5a, 32'h12345678};
        int oor [5] = '{26, 27, 31, 100, 1023};
        model_reset();
        repeat (4) @(negedge clk);
        check("R1 rdata in reset", rdata, 32'h0);
        check("R1 err in reset", err, 1'b0);
        rst_n = 1'b1;
        read_all("R1 R3 reset read", 0);
        check_ports("R10 R1");

        for (int p = 0; p < 5; p++) begin
            for (int i = 0; i < 30; i++) begin
                access(1'b1, 12'(i * 4 + ((i + p) % 4)), pats[p] ^ 32'(i));
                check("R8 write rdata", rdata, 32'h0);
                check("R8 R9 write err", err, !exp_wr(i));
                if (exp_wr(i)) model[i] = exp_store(i, pats[p] ^ 32'(i));
            end
            read_all("R2 R5 R6 R7 R8 readback", p + 1);
            check_ports("R10 after writes");
            check("R5 forced bit", ctrl_q[26], 1'b1);
        end

        foreach (oor[k]) begin
            access(1'b0, 12'(oor[k] * 4 + k % 4), 32'h0);
            check("R4 oor rdata", rdata, 32'h0);
            check("R4 oor err", err, 1'b1);
            @(negedge clk);
            check("R9 err pulse width", err, 1'b0);
            access(1'b1, 12'(oor[k] * 4), 32'hdeadbeef);
            check("R8 oor write err", err, 1'b1);
        end
        read_all("R8 after oor writes", 3);

        @(negedge clk);
        rst_n = 1'b0; req = 1'b1; we = 1'b1; addr = 12'h008; wdata = 32'hdeadbeef;
        repeat (3) @(negedge clk);
        req = 1'b0; we = 1'b0;
        rst_n = 1'b1;
        model_reset();
        read_all("R11 R1 write in reset", 2);
        check_ports("R11 ports");

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule